// File: doc/BRIEF.md
# Seven-to-one serial pixel deserializer

This block turns four serial data lanes and one serial clock lane back into a 28-bit parallel pixel word. All five lanes are sampled by a bit clock running at seven times the pixel rate, so each lane delivers seven bits per pixel. The clock lane carries a fixed 7-bit shape. The block searches the clock lane for that shape to find the word boundary. It then cuts all four data lanes at the same boundary and registers the pixel word once per pixel period. A lock flag rises once the boundary has been confirmed over several consecutive words.

The parallel word holds 24 colour bits in `pix_o[23:0]`, followed by horizontal sync, vertical sync, data enable and one general control bit in `pix_o[27:24]`. An output stage combines an active-low power-down input, an output-enable input and an edge-select input. From these it picks one of three output states: released (high impedance, shown as drive-enable flags), forced zero, or live data. In the live state a regenerated pixel clock is driven, with its strobe edge placed in the middle of each data word. A lane that is open or undriven reads as logic one. After power-down is released, the outputs are held in the forced-zero state for a programmable number of bit clocks.

Top module: `lvds7_deser`

## Requirements
- R1: Lane i (0..3) bit k (k = 0 is the first bit received after the word boundary, 0..6) appears on `pix_o[7*i+k]` of the word that word produced.
- R2: A word boundary is taken when the last seven clock-lane bits, in arrival order, are 1,1,0,0,0,1,1. All data lanes use the same boundary. While hunting for the boundary, any position is accepted; once tracking, the pattern is checked only every seventh bit clock.
- R3: `locked_o` rises with the fourth consecutive matching word. `valid_o` is a one-cycle pulse, sent together with each new word, only while locked and in the live state. No word is delivered without a pulse.
- R4: A tracked boundary whose clock-lane bits do not match the pattern clears `locked_o` on the next cycle, and the boundary hunt restarts.
- R5: With `pd_ni` low, `pix_oe_o` and `pclk_oe_o` are 0 whatever `oe_i` and `edge_sel_i` are.
- R6: With `pd_ni` high and `oe_i` low, both drive-enable flags are 1, `pix_o` is all zeros, `pclk_o` is 0 and `valid_o` stays 0.
- R7: In the live state `pclk_o` is high for 4 of the 7 bit clocks of each word. Take phase 0 as the cycle in which a new word appears. With `edge_sel_i` = 0, the clock is high in phases 0..3 and falls at phase 4. With `edge_sel_i` = 1, it is high in phases 4..6 and 0, and rises at phase 4.
- R8: After reset, or after `pd_ni` returns high, the outputs stay in the forced-zero state for `LOCK_WAIT_CYC` bit clocks, even with `oe_i` high.
- R9: A lane flagged in `lane_open_i` (bits 0..3 for the data lanes, bit 4 for the clock lane) reads as all ones. An open clock lane therefore never locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low |
| oe_i | input | 1 | Output enable |
| edge_sel_i | input | 1 | Strobe edge: 0 falling, 1 rising |
| dat_lane_i | input | 4 | Serial data lane bits |
| clk_lane_i | input | 1 | Serial clock lane bit |
| lane_open_i | input | 5 | Lane undriven flags, bit 4 = clock lane |
| pix_o | output | 28 | Parallel pixel word |
| pix_oe_o | output | 1 | Drive enable of pix_o (0 = high impedance) |
| pclk_o | output | 1 | Regenerated pixel clock |
| pclk_oe_o | output | 1 | Drive enable of pclk_o |
| valid_o | output | 1 | One-cycle pulse per new word |
| locked_o | output | 1 | Boundary lock |

## Verification
Word capture and the output-state decision can fall in the same cycle: a locked word may complete while power-down or output-enable is holding the outputs forced. The bench provokes this by streaming well-framed words through the framer while `oe_i` is low, while `pd_ni` is low, and during the wait after power-down is released. The scoreboard expects no word in these windows, so any `valid_o` or nonzero `pix_o` there counts as an error. The bench also checks that live delivery resumes with the correct words once the wait has run out.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  typedef enum logic [1:0] {
    OUT_HIZ  = 2'd0,
    OUT_ZERO = 2'd1,
    OUT_LIVE = 2'd2
  } out_mode_e;
endpackage

// File: rtl/lvds7_lane_shift.sv
module lvds7_lane_shift #(
  parameter int NLANE = 5,
  parameter int SER   = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NLANE-1:0]           bit_i,
  input  logic [NLANE-1:0]           open_i,
  output logic [NLANE-1:0][SER-1:0]  sr_o
);
  // newest bit enters at LSB; open lane reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o <= '0;
    end else begin
      for (int l = 0; l < NLANE; l++) begin
        sr_o[l] <= {sr_o[l][SER-2:0], bit_i[l] | open_i[l]};
      end
    end
  end
endmodule

// File: rtl/lvds7_framer.sv
module lvds7_framer #(
  parameter int             SER        = 7,
  parameter int             NDAT       = 4,
  parameter logic [SER-1:0] PAT        = 7'b1100011,
  parameter int             LOCK_WORDS = 4,
  localparam int            PW         = $clog2(SER),
  localparam int            WW         = NDAT * SER
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SER-1:0]            clk_sr_i,
  input  logic [NDAT-1:0][SER-1:0]  dat_sr_i,
  output logic [WW-1:0]             word_o,
  output logic                      wvalid_o,
  output logic                      locked_o,
  output logic [PW-1:0]             phase_o
);
  localparam int GW = $clog2(LOCK_WORDS + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_WORDS);
  localparam logic [GW-1:0] GOOD_PRE = GW'(LOCK_WORDS - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(SER - 1);

  logic [GW-1:0] good_q;
  logic [WW-1:0] word_d;
  logic          match, hunting, boundary, take, lost;

  assign match    = (clk_sr_i == PAT);
  assign hunting  = (good_q == '0);
  assign boundary = (phase_o == PH_LAST);
  assign take     = match && (hunting || boundary);
  assign lost     = !hunting && boundary && !match;
  assign locked_o = (good_q == GOOD_MAX);

  // oldest bit (bit 0) sits at the MSB of each shift register
  for (genvar i = 0; i < NDAT; i++) begin : g_lane
    for (genvar k = 0; k < SER; k++) begin : g_bit
      assign word_d[i*SER+k] = dat_sr_i[i][SER-1-k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o  <= '0;
      good_q   <= '0;
      word_o   <= '0;
      wvalid_o <= 1'b0;
    end else begin
      wvalid_o <= take && (good_q >= GOOD_PRE);
      if (take) begin
        phase_o <= '0;
        word_o  <= word_d;
        if (good_q != GOOD_MAX) good_q <= good_q + 1'b1;
      end else begin
        phase_o <= boundary ? '0 : phase_o + 1'b1;
        if (lost) good_q <= '0;
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= PH_LAST); // R2
  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost |=> !locked_o); // R4
  AST_LOCK_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> wvalid_o); // R3
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o |=> !wvalid_o); // R3
endmodule

// File: rtl/lvds7_outctl.sv
module lvds7_outctl
  import lvds7_pkg::*;
#(
  parameter int  SER           = 7,
  parameter int  WW            = 28,
  parameter int  CLK_HIGH      = 4,
  parameter int  LOCK_WAIT_CYC = 1000,
  localparam int PW            = $clog2(SER)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_ni,
  input  logic          oe_i,
  input  logic          edge_sel_i,
  input  logic [WW-1:0] word_i,
  input  logic          wvalid_i,
  input  logic [PW-1:0] phase_i,
  output logic [WW-1:0] pix_o,
  output logic          pix_oe_o,
  output logic          pclk_o,
  output logic          pclk_oe_o,
  output logic          valid_o
);
  localparam int WCW = $clog2(LOCK_WAIT_CYC + 1);
  localparam logic [WCW-1:0] WAIT_MAX = WCW'(LOCK_WAIT_CYC);
  localparam logic [PW-1:0]  FALL_PH  = PW'(CLK_HIGH);
  localparam logic [PW-1:0]  RISE_PH  = PW'(SER - CLK_HIGH + 1);

  logic [WCW-1:0] wait_q;
  logic           ready, clk_raw, live;
  out_mode_e      mode;

  assign ready = (wait_q == WAIT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wait_q <= '0;
    else if (!pd_ni) wait_q <= '0;
    else if (!ready) wait_q <= wait_q + 1'b1;
  end

  always_comb begin
    if (!pd_ni)              mode = OUT_HIZ;
    else if (!ready || !oe_i) mode = OUT_ZERO;
    else                      mode = OUT_LIVE;
  end

  // strobe edge lands at mid-word in both polarities
  assign clk_raw   = edge_sel_i ? ((phase_i == '0) || (phase_i >= RISE_PH))
                                : (phase_i < FALL_PH);
  assign live      = (mode == OUT_LIVE);
  assign pix_oe_o  = (mode != OUT_HIZ);
  assign pclk_oe_o = (mode != OUT_HIZ);
  assign pix_o     = live ? word_i : '0;
  assign pclk_o    = live && clk_raw;
  assign valid_o   = live && wvalid_i;

  AST_PD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> !pix_oe_o && !pclk_oe_o); // R5
  AST_OE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_ni && !oe_i |-> pix_oe_o && pclk_oe_o && pix_o == '0 && !pclk_o && !valid_o); // R6
  AST_WAIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !ready); // R8
  AST_VALID_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pd_ni && oe_i); // R3
endmodule

// File: rtl/lvds7_deser.sv
module lvds7_deser #(
  parameter int             LANES         = 4,
  parameter int             SER           = 7,
  parameter logic [SER-1:0] CLK_PAT       = 7'b1100011,
  parameter int             LOCK_WORDS    = 4,
  parameter int             CLK_HIGH      = 4,
  parameter int             LOCK_WAIT_CYC = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pd_ni,
  input  logic                 oe_i,
  input  logic                 edge_sel_i,
  input  logic [LANES-1:0]     dat_lane_i,
  input  logic                 clk_lane_i,
  input  logic [LANES:0]       lane_open_i,
  output logic [LANES*SER-1:0] pix_o,
  output logic                 pix_oe_o,
  output logic                 pclk_o,
  output logic                 pclk_oe_o,
  output logic                 valid_o,
  output logic                 locked_o
);
  localparam int WW = LANES * SER;
  localparam int PW = $clog2(SER);

  logic [LANES:0][SER-1:0]   sr;
  logic [LANES-1:0][SER-1:0] dat_sr;
  logic [WW-1:0]             word;
  logic                      wvalid;
  logic [PW-1:0]             phase;

  assign dat_sr = sr[LANES-1:0];

  lvds7_lane_shift #(.NLANE(LANES + 1), .SER(SER)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  ({clk_lane_i, dat_lane_i}),
    .open_i (lane_open_i),
    .sr_o   (sr)
  );

  lvds7_framer #(.SER(SER), .NDAT(LANES), .PAT(CLK_PAT), .LOCK_WORDS(LOCK_WORDS)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_sr_i (sr[LANES]),
    .dat_sr_i (dat_sr),
    .word_o   (word),
    .wvalid_o (wvalid),
    .locked_o (locked_o),
    .phase_o  (phase)
  );

  lvds7_outctl #(.SER(SER), .WW(WW), .CLK_HIGH(CLK_HIGH), .LOCK_WAIT_CYC(LOCK_WAIT_CYC)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_ni      (pd_ni),
    .oe_i       (oe_i),
    .edge_sel_i (edge_sel_i),
    .word_i     (word),
    .wvalid_i   (wvalid),
    .phase_i    (phase),
    .pix_o      (pix_o),
    .pix_oe_o   (pix_oe_o),
    .pclk_o     (pclk_o),
    .pclk_oe_o  (pclk_oe_o),
    .valid_o    (valid_o)
  );

  AST_VALID_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o); // R3
endmodule

// File: tb/sim_lvds7_deser.sv
module sim_lvds7_deser;
  localparam int WAITC = 40;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst_ni, pd_ni, oe_i, edge_sel_i, clk_lane_i;
  logic [3:0]  dat_lane_i;
  logic [4:0]  lane_open_i;
  logic [27:0] pix_o;
  logic        pix_oe_o, pclk_o, pclk_oe_o, valid_o, locked_o;

  always #4 clk = ~clk;

  lvds7_deser #(.LOCK_WAIT_CYC(WAITC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni), .oe_i(oe_i), .edge_sel_i(edge_sel_i),
    .dat_lane_i(dat_lane_i), .clk_lane_i(clk_lane_i), .lane_open_i(lane_open_i),
    .pix_o(pix_o), .pix_oe_o(pix_oe_o), .pclk_o(pclk_o), .pclk_oe_o(pclk_oe_o),
    .valid_o(valid_o), .locked_o(locked_o)
  );

  int checks = 0;
  int errors = 0;
  int run    = 0;
  int hi, bad;
  logic [27:0] expq[$];
  logic [27:0] exp_w;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: serialises one word, predicts lock and pushes the expected word
  task automatic send_word(input logic [27:0] w, input bit good, input bit live);
    logic [27:0] eff;
    bit          ok;
    eff = w;
    for (int i = 0; i < 4; i++) if (lane_open_i[i]) eff[7*i +: 7] = '1;
    ok = good && !lane_open_i[4];
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) dat_lane_i[i] = w[7*i+k];
      clk_lane_i = good ? PAT[6-k] : 1'b0;
    end
    if (ok) begin
      if (run < 4) run++;
    end else begin
      run = 0;
    end
    if (ok && run == 4 && live) expq.push_back(eff);
  endtask

  task automatic stream(input int n, input bit live);
    for (int j = 0; j < n; j++) send_word(28'($urandom), 1'b1, live);
    send_word(28'($urandom), 1'b0, 1'b0);
  endtask

  task automatic shape(input logic [6:0] exp, input string req);
    logic [6:0] v;
    do @(negedge clk); while (!valid_o);
    v[6] = pclk_o;
    for (int j = 1; j < 7; j++) begin
      @(negedge clk);
      v[6-j] = pclk_o;
    end
    chk(v == exp, req, "pclk shape over phases 0..6", 32'(v), 32'(exp));
  endtask

  // monitor: scoreboard pop on every valid pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni === 1'b1 && valid_o) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected valid", 32'(pix_o), 32'd0);
        end else begin
          exp_w = expq.pop_front();
          chk(pix_o == exp_w, "R1", "word mapping", 32'(pix_o), 32'(exp_w));
          chk(locked_o, "R3", "locked with valid", 32'(locked_o), 32'd1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pd_ni = 1'b1; oe_i = 1'b0; edge_sel_i = 1'b0;
    dat_lane_i = '0; clk_lane_i = 1'b0; lane_open_i = '0;
    repeat (3) @(negedge clk);
    chk(pix_oe_o && pclk_oe_o && pix_o == 0 && !pclk_o, "R8", "reset forced-zero",
        {pix_oe_o, pclk_oe_o, pclk_o}, 32'h6);
    chk(!locked_o && !valid_o, "R3", "reset lock/valid", {locked_o, valid_o}, 32'd0);
    rst_ni = 1'b1;
    oe_i   = 1'b1;

    // R8: wait after reset keeps clock quiet
    hi = 0;
    repeat (WAITC - 5) begin @(negedge clk); hi += int'(pclk_o); end
    chk(hi == 0, "R8", "pclk during wait", hi, 0);
    repeat (20) @(negedge clk);
    hi = 0;
    repeat (7) begin @(negedge clk); hi += int'(pclk_o); end
    chk(hi == 4, "R7", "pclk high count per word", hi, 4);

    // R1 R2 R3 R7 falling strobe
    edge_sel_i = 1'b0;
    fork
      stream(8, 1'b1);
      shape(7'b1111000, "R7");
    join
    // R7 rising strobe
    edge_sel_i = 1'b1;
    fork
      stream(6, 1'b1);
      shape(7'b1000111, "R7");
    join

    // R4: broken clock-lane word drops lock
    for (int j = 0; j < 5; j++) send_word(28'($urandom), 1'b1, 1'b1);
    chk(locked_o, "R3", "locked after 5 words", 32'(locked_o), 32'd1);
    send_word(28'($urandom), 1'b0, 1'b1);
    fork
      send_word(28'($urandom), 1'b1, 1'b1);
      begin
        @(negedge clk); @(negedge clk);
        chk(!locked_o, "R4", "lock lost on mismatch", 32'(locked_o), 32'd0);
      end
    join
    stream(5, 1'b1);

    // R9: open data lane reads ones, open clock lane never locks
    lane_open_i = 5'b00100;
    stream(6, 1'b1);
    lane_open_i = 5'b10000;
    stream(6, 1'b1);
    chk(!locked_o, "R9", "open clock lane lock", 32'(locked_o), 32'd0);
    lane_open_i = '0;

    // R6: output enable low forces zero while words arrive
    oe_i = 1'b0;
    bad  = 0;
    fork
      stream(6, 1'b0);
      repeat (42) begin
        @(negedge clk);
        if (pix_o != 0 || pclk_o || !pix_oe_o || !pclk_oe_o) bad++;
      end
    join
    chk(bad == 0, "R6", "forced-zero cycles violated", bad, 0);
    oe_i = 1'b1;

    // R5: power-down releases outputs whatever oe/edge do
    pd_ni = 1'b0;
    bad   = 0;
    fork
      stream(6, 1'b0);
      repeat (42) begin
        @(negedge clk);
        if (pix_oe_o || pclk_oe_o) bad++;
      end
      begin
        repeat (20) @(negedge clk);
        oe_i = 1'b0; edge_sel_i = 1'b0;
        repeat (10) @(negedge clk);
        oe_i = 1'b1; edge_sel_i = 1'b1;
      end
    join
    chk(bad == 0, "R5", "drive enabled in power-down", bad, 0);

    // R8: wait restarts after power-down release
    pd_ni = 1'b1;
    hi    = 0;
    bad   = 0;
    fork
      stream(5, 1'b0);
      repeat (WAITC - 5) begin
        @(negedge clk);
        hi += int'(pclk_o);
        if (!pix_oe_o || pix_o != 0) bad++;
      end
    join
    chk(hi == 0, "R8", "pclk during wait after power-down", hi, 0);
    chk(bad == 0, "R8", "forced-zero during wait", bad, 0);

    stream(6, 1'b1);
    chk(expq.size() == 0, "R3", "expected words left", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule